// File: doc/BRIEF.md
# Integer Register-Register ALU

This block is the arithmetic core of an integer execute stage. It takes two XLEN-wide operands and a four-bit operation code and returns one XLEN-wide result. The supported operations are add, subtract, bitwise AND, OR and XOR, left shift, logical right shift, arithmetic right shift, and signed and unsigned less-than compare. XLEN is a parameter and may be 32 or 64. The result is purely combinational, so the surrounding pipeline registers it wherever it needs to.

A small decode front end sits beside the datapath. It takes a 32-bit instruction word and returns the three register indices and the operation code for that word. The caller can feed that code straight back into the operation input.

Every operation goes through the same fixed logic depth for any operand values. The shifter is a barrel of log2(XLEN) stages, and every stage is always traversed. There is no early exit for zero operands or zero shift amounts.

Top module: `alu_rr_core`

## Requirements
- R1: With op_i = 4'b0000 (alternate bit 3 clear, low three bits 000), result_o is opa_i + opb_i modulo 2^XLEN.
- R2: With op_i = 4'b1000, result_o is opa_i - opb_i modulo 2^XLEN.
- R3: With op_i low bits 001, result_o is opa_i shifted toward the MSB by the shift amount, and the vacated low bits are zero.
- R4: With op_i = 4'b0101, result_o is opa_i shifted toward the LSB by the shift amount, and the vacated high bits are zero.
- R5: With op_i = 4'b1101, result_o is opa_i shifted toward the LSB by the shift amount, and the vacated high bits are copies of opa_i[XLEN-1].
- R6: The shift amount is opb_i[4:0] when XLEN is 32 and opb_i[5:0] when XLEN is 64. All higher bits of opb_i have no effect on any shift result.
- R7: With op_i low bits 010, result_o is 1 when opa_i < opb_i as two's-complement values and 0 otherwise. Bits XLEN-1..1 are zero.
- R8: With op_i low bits 011, result_o is 1 when opa_i < opb_i as unsigned values and 0 otherwise. Bits XLEN-1..1 are zero.
- R9: Low bits 100 give opa_i XOR opb_i, 110 give OR, and 111 give AND, all bitwise.
- R10: op_i[3] has no effect unless the low bits are 000 or 101.
- R11: rd_idx_o = instr_i[11:7], rs1_idx_o = instr_i[19:15], rs2_idx_o = instr_i[24:20], and op_dec_o = {instr_i[30], instr_i[14:12]}.
- R12: result_o follows an input change with no clock edge, through a fixed-depth path with no value-dependent bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation: bit 3 is the alternate select, bits 2:0 the function code |
| opa_i | input | XLEN | First operand |
| opb_i | input | XLEN | Second operand; its low bits are the shift amount |
| instr_i | input | 32 | Instruction word for the decode front end |
| result_o | output | XLEN | Operation result |
| op_dec_o | output | 4 | Operation code decoded from instr_i |
| rd_idx_o | output | 5 | Destination register index |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |

## Verification
The bench runs the same set of patterns on a 32-bit instance and on a 64-bit instance. Expected results come from a bit-loop model inside the bench.

Shift cases use amounts of 0 and XLEN-1, and second operands whose bits above the shift field are set. These separate a correctly masked shift amount from one that reads too many bits, and separate zero fill from sign fill.

Compare cases pair the most negative value with the most positive one in both orders, and also compare equal values. Only the correct signedness gives the right answer on all three.

Random operands over all opcodes, and alternate-bit variants of the single-meaning opcodes, catch mux and subtract-select mistakes that directed values miss.

// File: rtl/alu_rr_pkg.sv
package alu_rr_pkg;

  typedef enum logic [2:0] {
    F3_ADDSUB = 3'b000,
    F3_SLL    = 3'b001,
    F3_SLT    = 3'b010,
    F3_SLTU   = 3'b011,
    F3_XOR    = 3'b100,
    F3_SRX    = 3'b101,
    F3_OR     = 3'b110,
    F3_AND    = 3'b111
  } alu_f3_e;

  typedef struct packed {
    logic    alt;
    alu_f3_e f3;
  } alu_op_t;

  typedef struct packed {
    logic    sub;
    logic    shl;
    logic    arith;
  } alu_ctl_t;

  function automatic alu_op_t unpack_op(input logic [3:0] raw);
    alu_op_t o;
    o.alt = raw[3];
    o.f3  = alu_f3_e'(raw[2:0]);
    return o;
  endfunction

  // The adder subtracts for the explicit subtract and for both compares.
  function automatic alu_ctl_t op_controls(input alu_op_t o);
    alu_ctl_t c;
    c.sub   = ((o.f3 == F3_ADDSUB) && o.alt) || (o.f3 == F3_SLT) || (o.f3 == F3_SLTU);
    c.shl   = (o.f3 == F3_SLL);
    c.arith = (o.f3 == F3_SRX) && o.alt;
    return c;
  endfunction

  function automatic logic is_shift(input alu_f3_e f);
    return (f == F3_SLL) || (f == F3_SRX);
  endfunction

  // Signed less-than from the sign bits and the sign of the difference.
  function automatic logic signed_lt(input logic a_msb, input logic b_msb, input logic d_msb);
    return (a_msb ^ b_msb) ? a_msb : d_msb;
  endfunction

endpackage

// File: rtl/alu_rr_decode.sv
module alu_rr_decode (
  input  logic [31:0] instr_i,
  output logic [3:0]  op_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o
);
  localparam int RD_LSB   = 7;
  localparam int F3_LSB   = 12;
  localparam int RS1_LSB  = 15;
  localparam int RS2_LSB  = 20;
  localparam int ALT_BIT  = 30;
  localparam int IDX_W    = 5;

  assign rd_o  = instr_i[RD_LSB  +: IDX_W];
  assign rs1_o = instr_i[RS1_LSB +: IDX_W];
  assign rs2_o = instr_i[RS2_LSB +: IDX_W];
  assign op_o  = {instr_i[ALT_BIT], instr_i[F3_LSB +: 3]};
endmodule

// File: rtl/alu_rr_addsub.sv
module alu_rr_addsub #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            carry_o,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  import alu_rr_pkg::*;

  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic [XLEN:0]   wide;

  assign b_eff   = b_i ^ {XLEN{sub_i}};
  assign wide    = {1'b0, a_i} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub_i};
  assign sum_o   = wide[MSB:0];
  assign carry_o = wide[XLEN];
  // With subtraction, no carry out means a borrow: a < b unsigned.
  assign lt_u_o  = ~carry_o;
  assign lt_s_o  = signed_lt(a_i[MSB], b_i[MSB], sum_o[MSB]);
endmodule

// File: rtl/alu_rr_logic.sv
module alu_rr_logic #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      sel_i,
  output logic [XLEN-1:0] y_o
);
  // sel_i: 00 xor, 10 or, 11 and (the low two bits of the function code)
  always_comb begin
    unique case (sel_i)
      2'b00:   y_o = a_i ^ b_i;
      2'b10:   y_o = a_i | b_i;
      2'b11:   y_o = a_i & b_i;
      default: y_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu_rr_shifter.sv
module alu_rr_shifter #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         a_i,
  input  logic [$clog2(XLEN)-1:0] amt_i,
  input  logic                    left_i,
  input  logic                    arith_i,
  output logic [XLEN-1:0]         y_o
);
  localparam int SHW = $clog2(XLEN);

  logic [XLEN-1:0] a_rev;
  logic [XLEN-1:0] stg [SHW+1];
  logic [XLEN-1:0] core_out;
  logic [XLEN-1:0] core_rev;
  logic            fill;

  // A left shift is a right shift of the bit-reversed value, reversed back.
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign a_rev[i]    = a_i[XLEN-1-i];
    assign core_rev[i] = core_out[XLEN-1-i];
  end

  assign fill   = arith_i & ~left_i & a_i[XLEN-1];
  assign stg[0] = left_i ? a_rev : a_i;

  // Every stage is always present in the path, whatever the shift amount.
  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{D{fill}}, stg[s][XLEN-1:D]} : stg[s];
  end

  assign core_out = stg[SHW];
  assign y_o      = left_i ? core_rev : core_out;
endmodule

// File: rtl/alu_rr_core.sv
module alu_rr_core #(
  parameter int XLEN = 64
) (
  input  logic [3:0]      op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [31:0]     instr_i,
  output logic [XLEN-1:0] result_o,
  output logic [3:0]      op_dec_o,
  output logic [4:0]      rd_idx_o,
  output logic [4:0]      rs1_idx_o,
  output logic [4:0]      rs2_idx_o
);
  import alu_rr_pkg::*;

  localparam int SHW = $clog2(XLEN);

  if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
    $error("alu_rr_core: XLEN must be 32 or 64");
  end

  alu_op_t         op;
  alu_ctl_t        ctl;
  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] sum;
  logic            carry;
  logic            lt_s;
  logic            lt_u;
  logic [XLEN-1:0] shift_y;
  logic [XLEN-1:0] logic_y;

  assign op    = unpack_op(op_i);
  assign ctl   = op_controls(op);
  assign shamt = opb_i[SHW-1:0];

  alu_rr_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op_dec_o),
    .rd_o    (rd_idx_o),
    .rs1_o   (rs1_idx_o),
    .rs2_o   (rs2_idx_o)
  );

  alu_rr_addsub #(.XLEN(XLEN)) u_add (
    .a_i     (opa_i),
    .b_i     (opb_i),
    .sub_i   (ctl.sub),
    .sum_o   (sum),
    .carry_o (carry),
    .lt_s_o  (lt_s),
    .lt_u_o  (lt_u)
  );

  alu_rr_shifter #(.XLEN(XLEN)) u_shf (
    .a_i     (opa_i),
    .amt_i   (shamt),
    .left_i  (ctl.shl),
    .arith_i (ctl.arith),
    .y_o     (shift_y)
  );

  alu_rr_logic #(.XLEN(XLEN)) u_log (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sel_i (op_i[1:0]),
    .y_o   (logic_y)
  );

  always_comb begin
    unique case (op.f3)
      F3_ADDSUB:               result_o = sum;
      F3_SLL, F3_SRX:          result_o = shift_y;
      F3_SLT:                  result_o = {{(XLEN-1){1'b0}}, lt_s};
      F3_SLTU:                 result_o = {{(XLEN-1){1'b0}}, lt_u};
      F3_XOR, F3_OR, F3_AND:   result_o = logic_y;
      default:                 result_o = sum;
    endcase
  end
endmodule

// File: rtl/alu_rr_chk.sv
module alu_rr_chk #(
  parameter int XLEN = 64
) (
  input logic [3:0]              op_i,
  input logic [XLEN-1:0]         opa_i,
  input logic [XLEN-1:0]         opb_i,
  input logic [XLEN-1:0]         result_o,
  input logic [$clog2(XLEN)-1:0] shamt,
  input logic                    lt_s,
  input logic                    lt_u
);
  import alu_rr_pkg::*;

  alu_f3_e f3;
  assign f3 = alu_f3_e'(op_i[2:0]);

  always_comb begin
    if (f3 == F3_SLT || f3 == F3_SLTU) begin
      assert_cmp_zext_R7: assert (result_o[XLEN-1:1] == '0)
        else $error("compare result not zero-extended");
    end
    if (f3 == F3_SLTU) begin
      assert_ult_R8: assert (result_o[0] == (opa_i < opb_i) && lt_u == result_o[0])
        else $error("unsigned compare wrong");
    end
    if (f3 == F3_SLT) begin
      assert_slt_R7: assert (result_o[0] == ($signed(opa_i) < $signed(opb_i)) && lt_s == result_o[0])
        else $error("signed compare wrong");
    end
    if (is_shift(f3) && shamt == '0) begin
      assert_zero_shift_R6: assert (result_o == opa_i)
        else $error("zero shift altered operand");
    end
    if (f3 == F3_SRX && !op_i[3] && shamt != '0) begin
      assert_srl_fill_R4: assert (result_o[XLEN-1] == 1'b0)
        else $error("logical right shift did not zero fill");
    end
    if (f3 == F3_SRX && op_i[3]) begin
      assert_sra_fill_R5: assert (result_o[XLEN-1] == opa_i[XLEN-1])
        else $error("arithmetic right shift lost sign");
    end
    if (f3 == F3_SLL && shamt != '0) begin
      assert_sll_fill_R3: assert (result_o[0] == 1'b0)
        else $error("left shift did not zero fill");
    end
    if (f3 == F3_AND) begin
      assert_and_subset_R9: assert ((result_o & ~(opa_i & opb_i)) == '0)
        else $error("AND result has stray ones");
    end
  end
endmodule

bind alu_rr_core alu_rr_chk #(.XLEN(XLEN)) u_chk (
  .op_i     (op_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .result_o (result_o),
  .shamt    (shamt),
  .lt_s     (lt_s),
  .lt_u     (lt_u)
);

// File: tb/tb_alu_rr_core.sv
`timescale 1ns/1ps
module tb_alu_rr_core;

  localparam time HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(HALF) clk = ~clk;

  logic [3:0]  op64 = '0, op32 = '0;
  logic [63:0] a64 = '0, b64 = '0, r64;
  logic [31:0] a32 = '0, b32 = '0, r32;
  logic [31:0] instr = '0;
  logic [3:0]  dop64, dop32;
  logic [4:0]  rd64, rs1_64, rs2_64, rd32, rs1_32, rs2_32;

  alu_rr_core #(.XLEN(64)) dut (
    .op_i(op64), .opa_i(a64), .opb_i(b64), .instr_i(instr), .result_o(r64),
    .op_dec_o(dop64), .rd_idx_o(rd64), .rs1_idx_o(rs1_64), .rs2_idx_o(rs2_64)
  );

  alu_rr_core #(.XLEN(32)) dut32 (
    .op_i(op32), .opa_i(a32), .opb_i(b32), .instr_i(instr), .result_o(r32),
    .op_dec_o(dop32), .rd_idx_o(rd32), .rs1_idx_o(rs1_32), .rs2_idx_o(rs2_32)
  );

  typedef struct {
    int          n;
    logic [3:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int applied = 0;
  int bad = 0;

  function automatic logic [63:0] wmask(input int n);
    return (n == 64) ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF;
  endfunction

  // Reference model written bit by bit from the requirements.
  function automatic logic [63:0] model(input int n, input logic [3:0] op,
                                        input logic [63:0] ai, input logic [63:0] bi);
    logic [63:0] m, a, b, r;
    int sh;
    logic fill;
    m = wmask(n);
    a = ai & m;
    b = bi & m;
    sh = (n == 64) ? int'(b[5:0]) : int'(b[4:0]);
    r = '0;
    case (op[2:0])
      3'b000: r = op[3] ? (a - b) : (a + b);
      3'b001: for (int i = 0; i < n; i++) r[i] = (i >= sh) ? a[i-sh] : 1'b0;
      3'b010: r[0] = (a[n-1] != b[n-1]) ? a[n-1] : (a < b);
      3'b011: r[0] = (a < b);
      3'b100: r = a ^ b;
      3'b101: begin
        fill = op[3] ? a[n-1] : 1'b0;
        for (int i = 0; i < n; i++) r[i] = (i + sh < n) ? a[i+sh] : fill;
      end
      3'b110: r = a | b;
      default: r = a & b;
    endcase
    return r & m;
  endfunction

  task automatic fail_line(input string tag, input logic [63:0] got, input logic [63:0] exp);
    bad++;
    $display("FAIL %s: got %h expected %h", tag, got, exp);
  endtask

  // Driver: one item per cycle, pushed to the scoreboard queue.
  task automatic apply(input int n, input logic [3:0] op, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    if (n == 64) begin op64 = op; a64 = a; b64 = b; end
    else begin op32 = op; a32 = a[31:0]; b32 = b[31:0]; end
    it.n = n; it.op = op; it.a = a; it.b = b; it.tag = tag;
    it.exp = model(n, op, a, b);
    q.push_back(it);
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [63:0] got;
      it = q.pop_front();
      got = (it.n == 64) ? r64 : {32'b0, r32};
      applied++;
      if (got !== it.exp) fail_line($sformatf("%s xlen=%0d op=%h", it.tag, it.n, it.op), got, it.exp);
    end
  end

  task automatic directed(input int n);
    logic [63:0] m, mn, mx, hi_sh;
    m = wmask(n);
    mn = 64'd1 << (n - 1);
    mx = (mn - 64'd1) & m;
    hi_sh = m & ~((n == 64) ? 64'h3F : 64'h1F);
    apply(n, 4'b0000, m, 64'd1, "R1 add wraps");
    apply(n, 4'b0000, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, "R1 add");
    apply(n, 4'b1000, 64'd0, 64'd1, "R2 sub wraps");
    apply(n, 4'b1000, mn, 64'd1, "R2 sub");
    apply(n, 4'b0001, m, 64'd0, "R3 sll by 0");
    apply(n, 4'b0001, 64'd3, n - 1, "R3 sll by XLEN-1");
    apply(n, 4'b0001, 64'hA5A5_5A5A_F00F_0FF0, hi_sh | 64'd4, "R3 R6 sll masked amount");
    apply(n, 4'b0101, mn, n - 1, "R4 srl by XLEN-1");
    apply(n, 4'b0101, m, 64'd0, "R4 srl by 0");
    apply(n, 4'b0101, m, hi_sh | 64'd7, "R4 R6 srl masked amount");
    apply(n, 4'b1101, mn, n - 1, "R5 sra by XLEN-1");
    apply(n, 4'b1101, mn | 64'h55, hi_sh | 64'd3, "R5 R6 sra masked amount");
    apply(n, 4'b1101, mx, 64'd5, "R5 sra positive");
    apply(n, 4'b1101, mn, hi_sh, "R6 sra high bits only");
    apply(n, 4'b0010, mn, mx, "R7 slt min<max");
    apply(n, 4'b0010, mx, mn, "R7 slt max<min");
    apply(n, 4'b0010, mn, mn, "R7 slt equal");
    apply(n, 4'b0011, mn, mx, "R8 sltu min<max");
    apply(n, 4'b0011, mx, mn, "R8 sltu max<min");
    apply(n, 4'b0011, m, m, "R8 sltu equal");
    apply(n, 4'b0100, 64'hFF00_FF00_F0F0_3C3C, 64'h0FF0_0FF0_FFFF_0000, "R9 xor");
    apply(n, 4'b0110, 64'hFF00_FF00_F0F0_3C3C, 64'h0FF0_0FF0_FFFF_0000, "R9 or");
    apply(n, 4'b0111, 64'hFF00_FF00_F0F0_3C3C, 64'h0FF0_0FF0_FFFF_0000, "R9 and");
    apply(n, 4'b1100, 64'hDEAD_BEEF_0000_FFFF, 64'h1111_2222_3333_4444, "R10 alt xor");
    apply(n, 4'b1110, 64'hDEAD_BEEF_0000_FFFF, 64'h1111_2222_3333_4444, "R10 alt or");
    apply(n, 4'b1111, 64'hDEAD_BEEF_0000_FFFF, 64'h1111_2222_3333_4444, "R10 alt and");
    apply(n, 4'b1001, 64'h8000_0001_8000_0001, 64'd1, "R10 alt sll");
    apply(n, 4'b1010, mn, mx, "R10 alt slt");
    apply(n, 4'b1011, mn, mx, "R10 alt sltu");
    for (int k = 0; k < 150; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply(n, 4'($urandom % 16), ra, rb, "RAND R1..R10");
    end
  endtask

  task automatic check_decode(input logic [31:0] w, input string tag);
    @(posedge clk);
    #1 instr = w;
    #2;
    applied++;
    if ({rd64, rs1_64, rs2_64, dop64} !== {w[11:7], w[19:15], w[24:20], w[30], w[14:12]})
      fail_line({tag, " xlen=64"}, {45'b0, rd64, rs1_64, rs2_64, dop64},
                {45'b0, w[11:7], w[19:15], w[24:20], w[30], w[14:12]});
    applied++;
    if ({rd32, rs1_32, rs2_32, dop32} !== {w[11:7], w[19:15], w[24:20], w[30], w[14:12]})
      fail_line({tag, " xlen=32"}, {45'b0, rd32, rs1_32, rs2_32, dop32},
                {45'b0, w[11:7], w[19:15], w[24:20], w[30], w[14:12]});
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 2 * HALF);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: all-zero inputs select add of zeros (R1).
    applied++;
    if (r64 !== 64'd0) fail_line("R1 idle result xlen=64", r64, 64'd0);
    applied++;
    if (r32 !== 32'd0) fail_line("R1 idle result xlen=32", {32'b0, r32}, 64'd0);

    directed(64);
    directed(32);
    while (q.size() > 0) @(posedge clk);

    check_decode(32'h4062_D5B3, "R11 decode fields");
    check_decode(32'h01F0_80B3, "R11 decode fields");
    check_decode(32'hBFFF_FFFF, "R11 decode fields");

    // R12: result follows inputs between clock edges.
    @(negedge clk);
    #3 op64 = 4'b0000; a64 = 64'd40; b64 = 64'd2;
    #1;
    applied++;
    if (r64 !== 64'd42) fail_line("R12 no-clock response", r64, 64'd42);
    #1 op64 = 4'b1000;
    #1;
    applied++;
    if (r64 !== 64'd38) fail_line("R12 no-clock response", r64, 64'd38);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule